// File: doc/BRIEF.md
# Receive Descriptor Status Generator

This block follows one received Ethernet frame while it is laid into a chain of host memory buffers and produces the status word written back for each buffer. The receive path tells it when a frame starts and ends, and when the current buffer fills and the frame has to continue in the next one. It also reports the octet alignment of the frame length, the FCS check result, receive errors signalled by the PHY, FIFO overflows and bus parity errors. The descriptor fetch logic reports the OWN bit of the next descriptor once it has been read. The block then raises a one-cycle write strobe together with the status flags for the buffer that has just been closed.

The flags depend on each other. A framing error needs an FCS error as well. An overflow is reported next to a buffer error only when the two coincide. The framing, CRC and parity flags appear only in the status that terminates a frame. After a frame is cut short by a buffer or overflow error, the block ignores the rest of that frame until the next frame start.

Top module: `rxdesc_status_gen`

## Requirements
- R1: The summary error flag in a written status is high exactly when at least one of the framing, overflow, CRC, buffer or parity flags of that status is high.
- R2: On the end-of-packet status the framing flag is high only when the length is not a whole number of octets (`dribble`) and `fcsBad` is also high. A non-octet length with a good FCS leaves it low.
- R3: While `loopback` is 1 the framing flag is never set. The framing and CRC flags are never set in a status that lacks end-of-packet or carries overflow.
- R4: The CRC flag of the end-of-packet status is also set when `phyRxErr` pulsed at any cycle of the frame, up to and including the end cycle, even with a good FCS.
- R5: Start-of-packet is set only in the status of the first buffer of a frame, and end-of-packet only in the status of the last. A frame held in one buffer gets both in a single status.
- R6: After `bufClose`, an OWN read of 0 (`ownValid`=1, `ownBit`=0) writes the closed buffer's status with the buffer flag set and end-of-packet clear.
- R7: A `fifoOvf` pulse while the next OWN bit is still outstanding writes the buffer flag with overflow clear. Overflow is also set only when `fifoOvf` comes in the same cycle as an OWN read of 0.
- R8: A `fifoOvf` pulse while a buffer is being filled writes that buffer's status with overflow set and end-of-packet clear.
- R9: The parity flag is set only when `parityEn` is 1, `desc16` is 0 and `busParErr` pulsed during the frame. It appears only in the status that ends the frame (end-of-packet, overflow or buffer error) and is 0 in all intermediate statuses.
- R10: After a buffer or overflow error, and after a frame has ended, `bufClose`, `frameEnd` and `fifoOvf` produce no status write until the next `frameStart`.
- R11: Exactly one status is written per buffer, in the cycle after the event that closes it: `frameEnd`, `fifoOvf`, or the OWN read that follows `bufClose`. `bufClose` alone writes nothing. Sticky errors are cleared by `frameStart`.
- R12: Among events in the same cycle the priority is `frameStart`, then `fifoOvf`, then `frameEnd`, then `bufClose`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Pulse: a new frame begins in a fresh buffer |
| bufClose | input | 1 | Pulse: current buffer full, frame continues |
| frameEnd | input | 1 | Pulse: last octet of the frame stored |
| dribble | input | 1 | With frameEnd: length is not a whole number of octets |
| fcsBad | input | 1 | With frameEnd: FCS check failed |
| phyRxErr | input | 1 | Pulse: PHY signalled a receive error |
| fifoOvf | input | 1 | Pulse: receive FIFO overflowed |
| busParErr | input | 1 | Pulse: parity error on a buffer write |
| ownValid | input | 1 | Pulse: next descriptor OWN bit has been read |
| ownBit | input | 1 | OWN bit value, valid with ownValid |
| parityEn | input | 1 | Enables reporting of parity errors |
| desc16 | input | 1 | 16-bit descriptor layout, no parity flag |
| loopback | input | 1 | Internal loopback mode |
| stWr | output | 1 | One-cycle status write strobe |
| stErr | output | 1 | Summary error flag |
| stFram | output | 1 | Framing error flag |
| stOflo | output | 1 | Overflow flag |
| stCrc | output | 1 | CRC error flag |
| stBuff | output | 1 | Buffer error flag |
| stStp | output | 1 | Start-of-packet flag |
| stEnp | output | 1 | End-of-packet flag |
| stBpe | output | 1 | Bus parity error flag |

## Verification
Every status write is due exactly one clock after the closing event is sampled: the control stage decides in the same cycle and the datapath registers the word at that edge. The bench drives each event for one cycle from a falling edge and queues the status it expects for that event. The monitor samples `stWr` and the flags on the following falling edge, so each result is compared in the cycle it is due. A write with an empty queue, or queued items left at the end, counts as a miscompare. This also covers the ignored-event cases, because any stray write is caught the cycle it appears.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_WAIT_OWN,
    ST_DROP
  } rxState_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic clearFrame;
    logic isFirst;
    logic wrMid;
    logic wrEnd;
    logic wrOvf;
    logic wrBuff;
    logic buffOflo;
  } ctrlStrobe_t;

  typedef struct packed {
    logic err;
    logic fram;
    logic oflo;
    logic crc;
    logic buff;
    logic stp;
    logic enp;
    logic bpe;
  } rxStatus_t;

endpackage

// File: rtl/rxst_ctrl.sv
module rxst_ctrl
  import rxst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        bufClose,
  input  logic        frameEnd,
  input  logic        fifoOvf,
  input  logic        ownValid,
  input  logic        ownBit,
  output ctrlStrobe_t strb
);

  rxState_e state, stateNxt;
  logic     first, firstNxt;

  always_comb begin
    stateNxt     = state;
    firstNxt     = first;
    strb         = '0;
    strb.isFirst = first;
    if (frameStart) begin
      strb.clearFrame = 1'b1;
      stateNxt        = ST_RECV;
      firstNxt        = 1'b1;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (fifoOvf) begin
            strb.wrOvf = 1'b1;
            stateNxt   = ST_DROP;
          end else if (frameEnd) begin
            strb.wrEnd = 1'b1;
            stateNxt   = ST_IDLE;
          end else if (bufClose) begin
            stateNxt = ST_WAIT_OWN;
          end
        end
        ST_WAIT_OWN: begin
          if (fifoOvf) begin
            // overflow before or with the OWN read: buffer error
            strb.wrBuff   = 1'b1;
            strb.buffOflo = ownValid & ~ownBit;
            stateNxt      = ST_DROP;
          end else if (ownValid) begin
            if (ownBit) begin
              strb.wrMid = 1'b1;
              firstNxt   = 1'b0;
              stateNxt   = ST_RECV;
            end else begin
              strb.wrBuff = 1'b1;
              stateNxt    = ST_DROP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      first <= 1'b0;
    end else begin
      state <= stateNxt;
      first <= firstNxt;
    end
  end

endmodule

// File: rtl/rxst_data.sv
module rxst_data
  import rxst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic        dribble,
  input  logic        fcsBad,
  input  logic        phyRxErr,
  input  logic        busParErr,
  input  logic        parityEn,
  input  logic        desc16,
  input  logic        loopback,
  output logic        stWr,
  output rxStatus_t   st
);

  logic      phySticky, parSticky;
  logic      parityHit;
  logic      anyWr;
  rxStatus_t nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phySticky <= 1'b0;
      parSticky <= 1'b0;
    end else if (strb.clearFrame) begin
      phySticky <= 1'b0;
      parSticky <= 1'b0;
    end else begin
      if (phyRxErr)  phySticky <= 1'b1;
      if (busParErr) parSticky <= 1'b1;
    end
  end

  assign parityHit = (parSticky | busParErr) & parityEn & ~desc16;
  assign anyWr     = strb.wrMid | strb.wrEnd | strb.wrOvf | strb.wrBuff;

  always_comb begin
    nxt     = '0;
    nxt.stp = strb.isFirst;
    if (strb.wrEnd) begin
      nxt.enp  = 1'b1;
      nxt.crc  = fcsBad | phySticky | phyRxErr;
      nxt.fram = dribble & fcsBad & ~loopback;
      nxt.bpe  = parityHit;
    end else if (strb.wrOvf) begin
      nxt.oflo = 1'b1;
      nxt.bpe  = parityHit;
    end else if (strb.wrBuff) begin
      nxt.buff = 1'b1;
      nxt.oflo = strb.buffOflo;
      nxt.bpe  = parityHit;
    end
    nxt.err = nxt.fram | nxt.oflo | nxt.crc | nxt.buff | nxt.bpe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stWr <= 1'b0;
      st   <= '0;
    end else begin
      stWr <= anyWr;
      if (anyWr) st <= nxt;
    end
  end

endmodule

// File: rtl/rxdesc_status_gen.sv
module rxdesc_status_gen
  import rxst_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic frameStart,
  input  logic bufClose,
  input  logic frameEnd,
  input  logic dribble,
  input  logic fcsBad,
  input  logic phyRxErr,
  input  logic fifoOvf,
  input  logic busParErr,
  input  logic ownValid,
  input  logic ownBit,
  input  logic parityEn,
  input  logic desc16,
  input  logic loopback,
  output logic stWr,
  output logic stErr,
  output logic stFram,
  output logic stOflo,
  output logic stCrc,
  output logic stBuff,
  output logic stStp,
  output logic stEnp,
  output logic stBpe
);

  ctrlStrobe_t strb;
  rxStatus_t   st;

  rxst_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .bufClose   (bufClose),
    .frameEnd   (frameEnd),
    .fifoOvf    (fifoOvf),
    .ownValid   (ownValid),
    .ownBit     (ownBit),
    .strb       (strb)
  );

  rxst_data i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dribble   (dribble),
    .fcsBad    (fcsBad),
    .phyRxErr  (phyRxErr),
    .busParErr (busParErr),
    .parityEn  (parityEn),
    .desc16    (desc16),
    .loopback  (loopback),
    .stWr      (stWr),
    .st        (st)
  );

  assign stErr  = st.err;
  assign stFram = st.fram;
  assign stOflo = st.oflo;
  assign stCrc  = st.crc;
  assign stBuff = st.buff;
  assign stStp  = st.stp;
  assign stEnp  = st.enp;
  assign stBpe  = st.bpe;

endmodule

// File: rtl/rxst_checker.sv
module rxst_checker (
  input logic clk,
  input logic rstN,
  input logic phyRxErr,
  input logic parityEn,
  input logic desc16,
  input logic loopback,
  input logic stWr,
  input logic stErr,
  input logic stFram,
  input logic stOflo,
  input logic stCrc,
  input logic stBuff,
  input logic stEnp,
  input logic stBpe
);

  AST_ERR_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !stFram && !stOflo && !stCrc && !stBuff && !stBpe) |-> !stErr); // R1

  AST_ERR_WITH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && (stFram || stOflo || stCrc || stBuff || stBpe)) |-> stErr); // R1

  AST_FRAM_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && stFram) |-> (stCrc && stEnp && !stOflo)); // R2

  AST_FRAM_LOOPBACK: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && $past(loopback)) |-> !stFram); // R3

  AST_CRC_ONLY_END: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && stCrc) |-> (stEnp && !stOflo)); // R3

  AST_PHY_ERR_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && stEnp && $past(phyRxErr)) |-> stCrc); // R4

  AST_BUFF_NO_ENP: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && stBuff) |-> !stEnp); // R6

  AST_BPE_CONTEXT: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && stBpe) |-> (stEnp || stOflo || stBuff)); // R9

  AST_BPE_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && ($past(desc16) || !$past(parityEn))) |-> !stBpe); // R9

endmodule

bind rxdesc_status_gen rxst_checker i_rxst_checker (
  .clk      (clk),
  .rstN     (rstN),
  .phyRxErr (phyRxErr),
  .parityEn (parityEn),
  .desc16   (desc16),
  .loopback (loopback),
  .stWr     (stWr),
  .stErr    (stErr),
  .stFram   (stFram),
  .stOflo   (stOflo),
  .stCrc    (stCrc),
  .stBuff   (stBuff),
  .stEnp    (stEnp),
  .stBpe    (stBpe)
);

// File: tb/test_rxdesc_status_gen.sv
module test_rxdesc_status_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, bufClose = 0, frameEnd = 0, dribble = 0, fcsBad = 0;
  logic phyRxErr = 0, fifoOvf = 0, busParErr = 0, ownValid = 0, ownBit = 0;
  logic parityEn = 0, desc16 = 0, loopback = 0;
  logic stWr, stErr, stFram, stOflo, stCrc, stBuff, stStp, stEnp, stBpe;

  int vectors = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdesc_status_gen i_rxdesc_status_gen (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bufClose(bufClose),
    .frameEnd(frameEnd), .dribble(dribble), .fcsBad(fcsBad), .phyRxErr(phyRxErr),
    .fifoOvf(fifoOvf), .busParErr(busParErr), .ownValid(ownValid), .ownBit(ownBit),
    .parityEn(parityEn), .desc16(desc16), .loopback(loopback),
    .stWr(stWr), .stErr(stErr), .stFram(stFram), .stOflo(stOflo), .stCrc(stCrc),
    .stBuff(stBuff), .stStp(stStp), .stEnp(stEnp), .stBpe(stBpe)
  );

  // reference word: {err,fram,oflo,crc,buff,stp,enp,bpe}; err is the OR (R1)
  function automatic logic [7:0] mk(input logic fram, oflo, crc, buff, stp, enp, bpe);
    return {fram | oflo | crc | buff | bpe, fram, oflo, crc, buff, stp, enp, bpe};
  endfunction

  task automatic expect_st(input logic [7:0] w, input string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
  endtask

  // monitor: compares every write against the queue
  always @(negedge clk) begin
    if (rstN && stWr && !done) begin
      logic [7:0] act;
      act = {stErr, stFram, stOflo, stCrc, stBuff, stStp, stEnp, stBpe};
      vectors++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R10/R11 unexpected write: actual %b expected none", act);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", t, act, e);
        end
      end
    end
  end

  // one cycle of stimulus, starting and ending on a falling edge
  task automatic step(input logic fs, bc, fe, drib, fcs, phy, ovf, par, ov, ob);
    frameStart = fs; bufClose = bc; frameEnd = fe; dribble = drib; fcsBad = fcs;
    phyRxErr = phy; fifoOvf = ovf; busParErr = par; ownValid = ov; ownBit = ob;
    @(negedge clk);
    frameStart = 0; bufClose = 0; frameEnd = 0; dribble = 0; fcsBad = 0;
    phyRxErr = 0; fifoOvf = 0; busParErr = 0; ownValid = 0; ownBit = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame();
    step(1,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic end_frame(input logic drib, fcs);
    step(0,0,1,drib,fcs,0,0,0,0,0);
  endtask

  task automatic chain_ok();
    step(0,1,0,0,0,0,0,0,0,0);
    idle(1);
    step(0,0,0,0,0,0,0,0,1,1);
  endtask

  task automatic finish_run();
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R11 missing writes: actual %0d pending expected 0", expQ.size());
    end
    vectors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    vectors++;
    if (stWr !== 1'b0 || stErr !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: actual %b%b expected 00", stWr, stErr);
    end

    // R5 single buffer, good frame
    start_frame(); idle(2);
    expect_st(mk(0,0,0,0,1,1,0), "R5 single buffer");
    end_frame(0,0); idle(2);

    // R1 R3 bad FCS, whole octets -> CRC only
    start_frame();
    expect_st(mk(0,0,1,0,1,1,0), "R1 fcs error");
    end_frame(0,1); idle(2);

    // R2 dribble with good FCS -> no framing
    start_frame();
    expect_st(mk(0,0,0,0,1,1,0), "R2 dribble good fcs");
    end_frame(1,0); idle(2);

    // R2 dribble with bad FCS -> framing and CRC
    start_frame();
    expect_st(mk(1,0,1,0,1,1,0), "R2 framing error");
    end_frame(1,1); idle(2);

    // R3 loopback suppresses framing
    loopback = 1;
    start_frame();
    expect_st(mk(0,0,1,0,1,1,0), "R3 loopback");
    end_frame(1,1); idle(2);
    loopback = 0;

    // R4 PHY error mid frame, good FCS
    start_frame();
    step(0,0,0,0,0,1,0,0,0,0); idle(2);
    expect_st(mk(0,0,1,0,1,1,0), "R4 phy error");
    end_frame(0,0); idle(2);

    // R4 PHY error in the end cycle
    start_frame();
    expect_st(mk(0,0,1,0,1,1,0), "R4 phy error at end");
    step(0,0,1,0,0,1,0,0,0,0); idle(2);

    // R5 R11 three-buffer frame
    start_frame();
    expect_st(mk(0,0,0,0,1,0,0), "R5 first of chain");
    chain_ok();
    expect_st(mk(0,0,0,0,0,0,0), "R5 middle of chain");
    chain_ok();
    expect_st(mk(0,0,0,0,0,1,0), "R5 last of chain");
    end_frame(0,0); idle(2);

    // R11 bufClose alone writes nothing, OWN read delayed
    start_frame();
    step(0,1,0,0,0,0,0,0,0,0); idle(4);
    expect_st(mk(0,0,0,0,1,0,0), "R11 delayed own");
    step(0,0,0,0,0,0,0,0,1,1);
    expect_st(mk(0,0,0,0,0,1,0), "R11 end after delay");
    end_frame(0,0); idle(2);

    // R6 OWN=0, then R10 rest of frame ignored
    start_frame();
    step(0,1,0,0,0,0,0,0,0,0);
    expect_st(mk(0,0,0,1,1,0,0), "R6 own zero");
    step(0,0,0,0,0,0,0,0,1,0);
    step(0,1,0,0,0,0,0,0,0,0);
    step(0,0,1,0,1,0,0,0,0,0);
    step(0,0,0,0,0,0,1,0,0,0); idle(3);

    // R7 overflow before OWN read -> buffer only
    start_frame();
    step(0,1,0,0,0,0,0,0,0,0);
    expect_st(mk(0,0,0,1,1,0,0), "R7 ovf before own");
    step(0,0,0,0,0,0,1,0,0,0); idle(2);

    // R7 overflow with OWN=0 -> buffer and overflow
    start_frame();
    step(0,1,0,0,0,0,0,0,0,0);
    expect_st(mk(0,1,0,1,1,0,0), "R7 ovf with own zero");
    step(0,0,0,0,0,0,1,0,1,0); idle(2);

    // R8 overflow in second buffer, then R10 end ignored
    start_frame();
    expect_st(mk(0,0,0,0,1,0,0), "R8 first buffer");
    chain_ok();
    expect_st(mk(0,1,0,0,0,0,0), "R8 overflow");
    step(0,0,0,0,0,0,1,0,0,0);
    end_frame(1,1); idle(2);

    // R10 events after frame end ignored
    step(0,1,0,0,0,0,0,0,0,0);
    end_frame(0,0);
    step(0,0,0,0,0,0,1,0,0,0); idle(2);

    // R9 parity reporting
    parityEn = 1;
    start_frame();
    step(0,0,0,0,0,0,0,1,0,0);
    expect_st(mk(0,0,0,0,1,0,0), "R9 no bpe mid buffer");
    chain_ok();
    expect_st(mk(0,0,0,0,0,1,1), "R9 bpe at end");
    end_frame(0,0); idle(2);

    start_frame();
    step(0,1,0,0,0,0,0,1,0,0);
    expect_st(mk(0,0,0,1,1,0,1), "R9 bpe with buffer error");
    step(0,0,0,0,0,0,0,0,1,0); idle(2);

    desc16 = 1;
    start_frame();
    step(0,0,0,0,0,0,0,1,0,0);
    expect_st(mk(0,0,0,0,1,1,0), "R9 16-bit mode");
    end_frame(0,0); idle(2);
    desc16 = 0; parityEn = 0;

    start_frame();
    step(0,0,0,0,0,0,0,1,0,0);
    expect_st(mk(0,0,0,0,1,1,0), "R9 parity disabled");
    end_frame(0,0); idle(2);

    // R11 frameStart clears sticky errors
    start_frame();
    step(0,0,0,0,0,1,0,0,0,0);
    start_frame();
    expect_st(mk(0,0,0,0,1,1,0), "R11 sticky cleared");
    end_frame(0,0); idle(2);

    // R12 priorities
    start_frame();
    expect_st(mk(0,0,0,0,1,1,0), "R12 end over close");
    step(0,1,1,0,0,0,0,0,0,0); idle(2);

    start_frame();
    expect_st(mk(0,1,0,0,1,0,0), "R12 ovf over end");
    step(0,0,1,0,1,0,1,0,0,0); idle(2);

    start_frame();
    step(1,0,1,0,0,0,1,0,0,0);
    expect_st(mk(0,0,0,0,1,1,0), "R12 start wins");
    end_frame(0,0); idle(3);

    done = 1;
    finish_run();
  end

endmodule